// File: doc/BRIEF.md
# Band-limited envelope and compensated drive splitter

This block sits in front of a supply-modulated switching amplifier. It takes one complex baseband sample at a time and produces two drive values. The first is a supply level `u`: an estimate of the sample's magnitude is smoothed by a first-order recursive low-pass filter, and a programmable offset is added to it. The second is an input drive `s`: both components of the sample divided by `u`. Because the amplifier multiplies its input drive by its supply, the product `u·s` gives back the original sample.

The filter coefficient sets how much of the magnitude variation reaches the supply and how much is left in the drive. A coefficient of one makes `u` follow the magnitude exactly, so `s` keeps a constant unit magnitude. A coefficient of zero leaves `u` at the constant offset, so `s` is the sample itself. When the supply falls below the sample magnitude, the output is flagged as clipped and the divisor becomes the magnitude, which saturates `s` to unit magnitude.

Samples enter through a valid/ready handshake. Two restoring dividers, one for I and one for Q, run side by side and produce one quotient bit per clock. `ready_o` stays low until their result has been delivered.

Top module: `env_polar_split`

## Requirements
- R1: A sample is accepted on a rising edge where `valid_i` and `ready_o` are both high. `ready_o` is low in the cycle after acceptance. `valid_o` goes high for exactly one cycle, 17 rising edges after the accepting edge. `ready_o` is high again in that same cycle.
- R2: The magnitude estimate is m = max(|I|,|Q|) + floor(min(|I|,|Q|)/4), using 16-bit two's-complement I and Q and an unsigned result.
- R3: On every accepted sample, the filter state y is updated as y += floor(a·(m − y)/32768), where a = min(`alpha_i`, 0x8000). Between accepted samples y does not change. Values of `alpha_i` above 0x8000 behave exactly as 0x8000.
- R4: `u_o` = min(y + `dc_i`, 0xFFFF), where y is the state already updated with the same sample. `u_o` is unsigned Q1.15, so 0x8000 means 1.0.
- R5: `clip_o` is 1 exactly when `u_o` < m for that sample.
- R6: Each drive component equals sign(x)·min(floor(|x|·32768/d), 32767), with d = max(`u_o`, m). If d = 0, both components are 0.
- R7: With a ≥ 0x8000 and `dc_i` = 0, `u_o` equals m and `clip_o` is 0.
- R8: With y = 0, alpha = 0 and `dc_i` = 0x8000, `u_o` is 0x8000. For any sample with m ≤ 0x8000 and no component equal to −32768, the drive components equal the input components.
- R9: While reset is held, `ready_o` = 1, `valid_o` = 0, `clip_o` = 0, `u_o`, `s_i_o` and `s_q_o` are all 0, and y = 0.
- R10: `alpha_i`, `dc_i`, `i_i` and `q_i` are sampled only at the accepting edge. Changing them while a division is running has no effect on the result that comes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample present |
| ready_o | output | 1 | Block can accept a sample |
| i_i | input | 16 | In-phase sample, signed Q1.15 |
| q_i | input | 16 | Quadrature sample, signed Q1.15 |
| alpha_i | input | 16 | Filter coefficient, unsigned Q1.15, clamped to 1.0 |
| dc_i | input | 16 | Supply offset, unsigned Q1.15 |
| valid_o | output | 1 | Output sample present, one-cycle pulse |
| u_o | output | 16 | Supply envelope, unsigned Q1.15 |
| s_i_o | output | 16 | In-phase drive, signed Q1.15 |
| s_q_o | output | 16 | Quadrature drive, signed Q1.15 |
| clip_o | output | 1 | Supply was below the sample magnitude |

## Verification
The bench drives the block with several classes of sample:
- Samples with a coefficient of one and no offset check that the supply tracks the magnitude estimate and that nothing clips. They are placed on an axis, on the diagonal, at the most negative code and at zero, which tells the max/min estimator apart from a plain sum and exercises the zero-divisor rule.
- Samples with a coefficient of zero and a unit offset, sent straight after the filter state has been cleared, must return the input unchanged. This separates a correct division scale from an off-by-one shift.
- A repeated constant sample with a small coefficient shows the stepwise rise of the recursive filter, including its rounding toward minus infinity.
- Large samples on a small offset force clipping.
- A large offset saturates the supply.
- A long run of random back-to-back samples, with the configuration changed during every division, checks the handshake timing and shows that nothing leaks in while the block is busy.

// File: rtl/eps_pkg.sv
package eps_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned BETA_SH = 2;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } eps_state_e;
endpackage

// File: rtl/eps_mag.sv
module eps_mag #(
  parameter int unsigned W  = 16,
  parameter int unsigned SH = 2
) (
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] q_i,
  output logic        [W:0]   abs_i_o,
  output logic        [W:0]   abs_q_o,
  output logic        [W:0]   mag_o
);
  logic signed [W:0] ext_i, ext_q;
  logic        [W:0] mx, mn;

  always_comb begin
    ext_i   = {i_i[W-1], i_i};
    ext_q   = {q_i[W-1], q_i};
    abs_i_o = ext_i[W] ? (W+1)'(-ext_i) : ext_i;
    abs_q_o = ext_q[W] ? (W+1)'(-ext_q) : ext_q;
    if (abs_i_o >= abs_q_o) begin
      mx = abs_i_o;
      mn = abs_q_o;
    end else begin
      mx = abs_q_o;
      mn = abs_i_o;
    end
    mag_o = mx + (mn >> SH);
  end
endmodule

// File: rtl/eps_env_filt.sv
module eps_env_filt #(
  parameter int unsigned MW = 17,
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [MW-1:0] m_i,
  input  logic [AW-1:0] alpha_i,
  output logic [MW-1:0] y_nxt_o
);
  localparam int unsigned PW = MW + AW + 3;
  localparam logic [AW-1:0] ONE = AW'(1) << (AW - 1);
  localparam logic signed [PW-1:0] YMAX = PW'((64'd1 << MW) - 1);

  logic        [MW-1:0] y_q;
  logic        [AW-1:0] a;
  logic signed [MW+1:0] diff;
  logic signed [PW-1:0] diff_x, a_x, prod, step, ysum;

  always_comb begin
    a      = (alpha_i > ONE) ? ONE : alpha_i;
    diff   = $signed({2'b00, m_i}) - $signed({2'b00, y_q});
    diff_x = {{(PW-MW-2){diff[MW+1]}}, diff};
    a_x    = {{(PW-AW){1'b0}}, a};
    prod   = diff_x * a_x;
    step   = prod >>> (AW - 1);
    ysum   = $signed({{(PW-MW){1'b0}}, y_q}) + step;
    if (ysum > YMAX)      y_nxt_o = '1;
    else if (ysum < 0)    y_nxt_o = '0;
    else                  y_nxt_o = ysum[MW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_q <= '0;
    else if (en_i) y_q <= y_nxt_o;
  end

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_q));
  a_r3_zero_coef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (alpha_i == '0) |=> y_q == $past(y_q));
  a_r7_full_coef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (alpha_i >= ONE) |=> y_q == $past(m_i));
endmodule

// File: rtl/eps_rdiv.sv
module eps_rdiv #(
  parameter int unsigned DW = 17,
  parameter int unsigned QW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW+QW-1:0] num_i,
  input  logic [DW-1:0]    den_i,
  output logic             done_o,
  output logic [QW-1:0]    quo_o
);
  localparam int unsigned CW = $clog2(QW + 1);

  logic [DW-1:0] rem_q, den_q;
  logic [QW-1:0] lo_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [DW:0]   t;
  logic [DW+1:0] sub;
  logic          ge;

  always_comb begin
    t   = {rem_q, lo_q[QW-1]};
    sub = {1'b0, t} - {2'b00, den_q};
    ge  = !sub[DW+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      lo_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else if (start_i) begin
      rem_q  <= num_i[DW+QW-1:QW];
      lo_q   <= num_i[QW-1:0];
      den_q  <= den_i;
      cnt_q  <= CW'(QW);
      busy_q <= 1'b1;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else if (busy_q) begin
      rem_q  <= ge ? sub[DW-1:0] : t[DW-1:0];
      quo_o  <= {quo_o[QW-2:0], ge};
      lo_q   <= lo_q << 1;
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CW'(1));
      done_o <= (cnt_q == CW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  a_r6_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (den_q != '0) |-> rem_q < den_q);
  a_r6_rem_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (den_q != '0) |-> (ge ? !sub[DW] : !t[DW]));
  a_r1_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/env_polar_split.sv
module env_polar_split #(
  parameter int unsigned W = eps_pkg::DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] q_i,
  input  logic        [W-1:0] alpha_i,
  input  logic        [W-1:0] dc_i,
  output logic                valid_o,
  output logic        [W-1:0] u_o,
  output logic signed [W-1:0] s_i_o,
  output logic signed [W-1:0] s_q_o,
  output logic                clip_o
);
  import eps_pkg::*;

  localparam int unsigned MW = W + 1;
  localparam int unsigned DW = W + 1;
  localparam int unsigned QW = W;
  localparam logic [W-1:0] SMAX = W'((64'd1 << (W - 1)) - 1);
  localparam logic [W-1:0] SMIN = W'(64'd1 << (W - 1));

  eps_state_e    state_q;
  logic          acc;
  logic [MW-1:0] mag, abs_i, abs_q, y_nxt;
  logic [MW:0]   u_sum;
  logic [W-1:0]  u_c, u_q;
  logic          clip_c, clip_q, zden_q;
  logic [DW-1:0] den_c;
  logic [1:0]    neg_q, done;
  logic [1:0][QW-1:0]    quo;
  logic [1:0][MW-1:0]    absv;
  logic [1:0][W-1:0]     s_nxt;

  assign ready_o = (state_q == ST_IDLE);
  assign acc     = valid_i && ready_o;

  eps_mag #(.W(W), .SH(BETA_SH)) u_mag (
    .i_i     (i_i),
    .q_i     (q_i),
    .abs_i_o (abs_i),
    .abs_q_o (abs_q),
    .mag_o   (mag)
  );

  eps_env_filt #(.MW(MW), .AW(W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (acc),
    .m_i     (mag),
    .alpha_i (alpha_i),
    .y_nxt_o (y_nxt)
  );

  always_comb begin
    u_sum  = {1'b0, y_nxt} + {{(MW+1-W){1'b0}}, dc_i};
    u_c    = (u_sum > (MW+1)'({W{1'b1}})) ? '1 : u_sum[W-1:0];
    clip_c = ({1'b0, u_c} < mag);
    den_c  = clip_c ? mag : {1'b0, u_c};
  end

  assign absv[0] = abs_i;
  assign absv[1] = abs_q;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [W-1:0] qv;

    eps_rdiv #(.DW(DW), .QW(QW)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (acc),
      .num_i   ({1'b0, absv[g], {(W-1){1'b0}}}),
      .den_i   (den_c),
      .done_o  (done[g]),
      .quo_o   (quo[g])
    );

    assign qv       = (quo[g] > SMAX) ? SMAX : quo[g];
    assign s_nxt[g] = zden_q ? '0 : (neg_q[g] ? W'(-qv) : qv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      u_q     <= '0;
      clip_q  <= 1'b0;
      zden_q  <= 1'b0;
      neg_q   <= '0;
      valid_o <= 1'b0;
      u_o     <= '0;
      s_i_o   <= '0;
      s_q_o   <= '0;
      clip_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (acc) begin
        state_q <= ST_RUN;
        u_q     <= u_c;
        clip_q  <= clip_c;
        zden_q  <= (den_c == '0);
        neg_q   <= {q_i[W-1], i_i[W-1]};
      end else if (state_q == ST_RUN && (&done)) begin
        state_q <= ST_IDLE;
        valid_o <= 1'b1;
        u_o     <= u_q;
        clip_o  <= clip_q;
        s_i_o   <= s_nxt[0];
        s_q_o   <= s_nxt[1];
      end
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o);
  a_r1_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r1_ready_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);
  a_r6_drive_saturated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (s_i_o != SMIN) && (s_q_o != SMIN));
  a_r5_clip_below_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && clip_o |-> u_o < W'((64'd5 << (W - 1)) >> 2) + W'(1));
endmodule

// File: tb/env_polar_split_tb_top.sv
module env_polar_split_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic signed [15:0] i_i = '0, q_i = '0;
  logic [15:0] alpha_i = '0, dc_i = '0;
  logic        valid_o;
  logic [15:0] u_o;
  logic signed [15:0] s_i_o, s_q_o;
  logic        clip_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int busy_until = 0;
  int ym = 0;
  bit running = 1'b0;

  typedef struct {
    int due; int u; int si; int sq; int clip; int m; int xi; int xq; string tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  env_polar_split dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .i_i(i_i), .q_i(q_i), .alpha_i(alpha_i), .dc_i(dc_i),
    .valid_o(valid_o), .u_o(u_o), .s_i_o(s_i_o), .s_q_o(s_q_o), .clip_o(clip_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exv, cyc);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int drive_comp(input int x, input int d);
    longint qv;
    if (d == 0) return 0;
    qv = (longint'(iabs(x)) * 32768) / d;
    if (qv > 32767) qv = 32767;
    return (x < 0) ? -int'(qv) : int'(qv);
  endfunction

  task automatic send(input int xi, input int xq, input int al, input int dc, input string tg);
    exp_t e;
    int ai, aq, mx, mn, a, step, d;
    longint p;
    @(negedge clk); #1;
    valid_i = 1'b1; i_i = 16'(xi); q_i = 16'(xq); alpha_i = 16'(al); dc_i = 16'(dc);
    while (!ready_o) begin @(negedge clk); #1; end
    ai = iabs(xi); aq = iabs(xq);
    mx = (ai > aq) ? ai : aq;
    mn = (ai > aq) ? aq : ai;
    e.m = mx + mn / 4;
    a = (al > 32768) ? 32768 : al;
    p = longint'(e.m - ym) * a;
    step = (p >= 0) ? int'(p / 32768) : -int'((-p + 32767) / 32768);
    ym = ym + step;
    e.u = ym + dc;
    if (e.u > 65535) e.u = 65535;
    e.clip = (e.u < e.m) ? 1 : 0;
    d = e.clip ? e.m : e.u;
    e.si = drive_comp(xi, d);
    e.sq = drive_comp(xq, d);
    e.xi = xi; e.xq = xq; e.tag = tg;
    e.due = cyc + 18;
    busy_until = cyc + 18;
    expq.push_back(e);
    @(posedge clk); #1;
    // scramble everything while the division runs (R10)
    valid_i = 1'b0;
    alpha_i = 16'($urandom); dc_i = 16'($urandom);
    i_i = 16'($urandom); q_i = 16'($urandom);
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(ready_o == (cyc >= busy_until), "R1 ready_o", int'(ready_o), int'(cyc >= busy_until));
      if (expq.size() > 0 && expq[0].due == cyc) begin
        exp_t e;
        e = expq.pop_front();
        chk(valid_o == 1'b1, "R1 valid_o timing", int'(valid_o), 1);
        chk(int'(u_o) == e.u, (e.tag == "R10") ? "R10 u_o" : "R4 u_o", int'(u_o), e.u);
        chk(int'(clip_o) == e.clip, "R5 clip_o", int'(clip_o), e.clip);
        chk(int'(s_i_o) == e.si, "R6 s_i_o", int'(s_i_o), e.si);
        chk(int'(s_q_o) == e.sq, "R6 s_q_o", int'(s_q_o), e.sq);
        if (e.tag == "R7") begin
          chk(int'(u_o) == e.m, "R7/R2 u_o equals magnitude", int'(u_o), e.m);
          chk(clip_o == 1'b0, "R7 no clip", int'(clip_o), 0);
        end
        if (e.tag == "R8") begin
          chk(int'(u_o) == 32768, "R8 u_o", int'(u_o), 32768);
          chk(int'(s_i_o) == e.xi, "R8 s_i_o", int'(s_i_o), e.xi);
          chk(int'(s_q_o) == e.xq, "R8 s_q_o", int'(s_q_o), e.xq);
        end
      end else begin
        chk(valid_o == 1'b0, "R1 valid_o idle", int'(valid_o), 0);
      end
    end
  end

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1, "R9 ready_o", int'(ready_o), 1);
    chk(valid_o == 1'b0, "R9 valid_o", int'(valid_o), 0);
    chk(u_o == '0 && s_i_o == '0 && s_q_o == '0, "R9 data outputs", int'(u_o), 0);
    chk(clip_o == 1'b0, "R9 clip_o", int'(clip_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    running = 1'b1;
    // cleared filter: zero coefficient keeps y at 0 (R9, R8)
    send(1000, -2000, 0, 32768, "R8");
    // bypass
    send(16384, 0, 32768, 0, "R7");
    send(0, -16384, 32768, 0, "R7");
    send(12000, 12000, 32768, 0, "R7");
    send(-32768, 5, 32768, 0, "R7");
    send(300, -7, 32768, 0, "R7");
    send(0, 0, 32768, 0, "R7");
    // coefficient above one clamps
    send(20000, -3000, 65535, 0, "R3");
    // clear, then zero bandwidth
    send(0, 0, 32768, 0, "R7");
    send(20000, -9000, 0, 32768, "R8");
    send(-32767, 0, 0, 32768, "R8");
    send(32767, 32767, 0, 32768, "R5");
    // forced clipping on a small offset
    send(10000, 10000, 0, 4096, "R5");
    send(-20000, 3000, 0, 4096, "R5");
    // step response
    for (int k = 0; k < 6; k++) send(8000, -4000, 8192, 2048, "R3");
    for (int k = 0; k < 3; k++) send(0, 0, 8192, 2048, "R3");
    // supply saturation
    send(30000, 30000, 32768, 61440, "R4");
    // random back-to-back
    for (int k = 0; k < 40; k++)
      send(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($urandom_range(0, 40000)), int'($urandom_range(0, 65535)), "R10");
    repeat (25) @(negedge clk);
    chk(expq.size() == 0, "R1 all results delivered", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule